// File: doc/BRIEF.md
# Embedded Operation Status Reporter

This block sits on the read path of a byte-wide nonvolatile array. It decides what byte a read returns while an internal program or erase operation is running. When the array is idle, every read returns the true array byte at the read address. When an operation is running, every read instead returns a status byte. Its top bit is a polling flag, and the bit below it toggles from one read to the next. A host can therefore poll the array until the operation finishes.

An operation starts with a one-cycle start pulse. The pulse carries the operation kind, the target address and the data byte. The operation ends with a one-cycle done pulse from the timing engine, which lies outside this block. The block remembers:

- whether it is busy,
- whether the running operation is a program,
- the target address,
- bit 7 of the byte being programmed.

It also keeps one toggle flop. Two read sources exist, a chip-enable read and an output-enable read, and either one counts as a read. The output byte is registered. It updates on the clock edge at which a read is seen and holds its value between reads.

Top module: `opstat_reporter`

## Requirements
- R1: After reset the output byte is 0x00, the block is not busy, and the first read returns the array byte at the read address.
- R2: When not busy, a read (ce_read or oe_read high at a rising edge) loads rd_data with arr_data of that cycle, visible after that edge. With no read, rd_data holds its value.
- R3: While a program is busy (op_kind 0), a read at the program address returns bit 7 equal to the complement of bit 7 of the data being programmed.
- R4: While an erase is busy (any nonzero op_kind), a read returns bit 7 equal to 0.
- R5: While busy, a read at an address other than the program address, or any read during an erase, returns bit 7 as 0, bit 6 as the toggle value, and all other bits 0.
- R6: While busy, bits 5 down to 0 of every returned byte are 0.
- R7: An accepted start clears the toggle. The first busy read returns bit 6 as 0, and each further busy read at any address returns the inverse of the previous one.
- R8: A ce_read alone and an oe_read alone each count as one read that advances bit 6. Both high in the same cycle count as a single read.
- R9: A done pulse while busy ends the operation. From the next read on, reads return true array data, and bit 6 no longer toggles.
- R10: A start pulse while busy is ignored. The running operation keeps its kind, address and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_start | input | 1 | One-cycle pulse that starts an operation |
| op_kind | input | 2 | 0 = program, 1/2/3 = page, sector or chip erase |
| op_addr | input | ADDR_W | Target address of the operation |
| op_data | input | DATA_W | Byte being programmed |
| op_done | input | 1 | One-cycle pulse from the timing engine that ends the operation |
| ce_read | input | 1 | Read strobe produced by a chip-enable toggle |
| oe_read | input | 1 | Read strobe produced by an output-enable toggle |
| rd_addr | input | ADDR_W | Read address |
| arr_data | input | DATA_W | Array byte at rd_addr |
| rd_data | output | DATA_W | Registered read result |

## Verification
The main function is tried in three situations:

- **Idle reads at several addresses.** These show that true array data passes through.
- **Busy reads during a program.** These cover data with bit 7 clear and data with bit 7 set, read both at the programmed address and beside it. This tells the complemented polling bit apart from the forced-zero bit.
- **Busy reads during an erase.** These show that bit 7 stays 0 at every address.

Runs of ce-only, oe-only and simultaneous strobes check that the toggle counts reads rather than edges. A second start issued in the middle of a program, with different data and a different address, tells an ignored start from a reloaded one. Reads taken just after done, and a new start taken while the toggle is high, show the return to read mode and the clearing of the toggle.

// File: rtl/opstat_pkg.sv
package opstat_pkg;
  typedef enum logic [1:0] {
    OPK_PROGRAM = 2'd0,
    OPK_PAGE    = 2'd1,
    OPK_SECTOR  = 2'd2,
    OPK_CHIP    = 2'd3
  } op_kind_e;
endpackage

// File: rtl/opstat_tracker.sv
module opstat_tracker
  import opstat_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_start,
  input  logic [1:0]        op_kind,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [DATA_W-1:0] op_data,
  input  logic              op_done,
  output logic              busy,
  output logic              is_prog,
  output logic              prog_msb,
  output logic [ADDR_W-1:0] tgt_addr,
  output logic              accept
);
  localparam int MSB = DATA_W - 1;

  assign accept = op_start && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      is_prog  <= 1'b0;
      prog_msb <= 1'b0;
      tgt_addr <= '0;
    end else if (busy) begin
      if (op_done) busy <= 1'b0;
    end else if (op_start) begin
      busy     <= 1'b1;
      is_prog  <= (op_kind_e'(op_kind) == OPK_PROGRAM);
      prog_msb <= op_data[MSB];
      tgt_addr <= op_addr;
    end
  end

  // R9: done while busy returns the block to read mode
  assert_done_ends_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && op_done) |=> !busy);

  // R10: a start during a running operation leaves its context untouched
  assert_start_ignored_R10: assert property (@(posedge clk) disable iff (rst)
    (busy && op_start && !op_done) |=> (busy && $stable(tgt_addr) && $stable(prog_msb) && $stable(is_prog)));
endmodule

// File: rtl/opstat_toggle.sv
module opstat_toggle (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic advance,
  output logic tog
);
  always_ff @(posedge clk) begin
    if (rst || clear) tog <= 1'b0;
    else if (advance) tog <= ~tog;
  end

  // R7: each counted busy read inverts the toggle
  assert_toggle_flip_R7: assert property (@(posedge clk) disable iff (rst)
    (advance && !clear) |=> (tog != $past(tog)));

  // R7: an accepted start clears the toggle
  assert_toggle_clear_R7: assert property (@(posedge clk) disable iff (rst)
    clear |=> !tog);
endmodule

// File: rtl/opstat_reporter.sv
module opstat_reporter #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_start,
  input  logic [1:0]        op_kind,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [DATA_W-1:0] op_data,
  input  logic              op_done,
  input  logic              ce_read,
  input  logic              oe_read,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] arr_data,
  output logic [DATA_W-1:0] rd_data
);
  localparam int POLL_BIT = DATA_W - 1;
  localparam int TOG_BIT  = DATA_W - 2;

  logic              busy, is_prog, prog_msb, accept, tog;
  logic [ADDR_W-1:0] tgt_addr;
  logic              rd_any, at_target;
  logic [DATA_W-1:0] status_byte;

  opstat_tracker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_track (
    .clk(clk), .rst(rst), .op_start(op_start), .op_kind(op_kind),
    .op_addr(op_addr), .op_data(op_data), .op_done(op_done),
    .busy(busy), .is_prog(is_prog), .prog_msb(prog_msb),
    .tgt_addr(tgt_addr), .accept(accept)
  );

  assign rd_any = ce_read || oe_read;

  opstat_toggle u_tog (
    .clk(clk), .rst(rst), .clear(accept),
    .advance(rd_any && busy), .tog(tog)
  );

  assign at_target = (rd_addr == tgt_addr);

  always_comb begin
    status_byte           = '0;
    status_byte[POLL_BIT] = is_prog && at_target && !prog_msb;
    status_byte[TOG_BIT]  = tog;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else if (rd_any) rd_data <= busy ? status_byte : arr_data;
  end

  // R1: reset leaves the output cleared
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (rd_data == '0));

  // R2: idle reads pass the array byte
  assert_idle_true_R2: assert property (@(posedge clk) disable iff (rst)
    (rd_any && !busy) |=> (rd_data == $past(arr_data)));

  // R2: the output holds between reads
  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !rd_any |=> $stable(rd_data));

  // R6: low status bits are zero while busy
  assert_low_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_any && busy) |=> (rd_data[TOG_BIT-1:0] == '0));

  // R4 R5: polling bit is zero for erases and off-target reads
  assert_poll_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_any && busy && (!is_prog || !at_target)) |=> !rd_data[POLL_BIT]);
endmodule

// File: tb/opstat_reporter_bench.sv
module opstat_reporter_bench;
  localparam int AW = 19;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          op_start = 1'b0, op_done = 1'b0;
  logic [1:0]    op_kind = 2'd0;
  logic [AW-1:0] op_addr = '0, rd_addr = '0;
  logic [DW-1:0] op_data = '0;
  logic          ce_read = 1'b0, oe_read = 1'b0;
  logic [DW-1:0] arr_data, rd_data;

  int n_checks = 0, n_errors = 0;
  bit finished = 0;

  // bench-side model state
  bit          m_busy = 0, m_prog = 0, m_msb = 0, m_tog = 0;
  logic [AW-1:0] m_addr = '0;

  always #5 clk = ~clk;

  function automatic logic [DW-1:0] arr_of(input logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  assign arr_data = arr_of(rd_addr);

  opstat_reporter #(.ADDR_W(AW), .DATA_W(DW)) u_opstat_reporter (
    .clk(clk), .rst(rst), .op_start(op_start), .op_kind(op_kind),
    .op_addr(op_addr), .op_data(op_data), .op_done(op_done),
    .ce_read(ce_read), .oe_read(oe_read), .rd_addr(rd_addr),
    .arr_data(arr_data), .rd_data(rd_data)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  // sel: 1 = ce only, 2 = oe only, 3 = both
  task automatic do_read(input int sel, input logic [AW-1:0] a, input string req);
    logic [DW-1:0] exp;
    if (m_busy) begin
      exp = {(m_prog && a == m_addr && !m_msb), m_tog, 6'b0};
      m_tog = ~m_tog;
    end else exp = arr_of(a);
    @(negedge clk);
    rd_addr = a; ce_read = sel[0]; oe_read = sel[1];
    @(negedge clk);
    ce_read = 1'b0; oe_read = 1'b0;
    check(req, rd_data, exp);
  endtask

  task automatic start_op(input logic [1:0] k, input logic [AW-1:0] a, input logic [DW-1:0] d);
    if (!m_busy) begin
      m_busy = 1; m_prog = (k == 2'd0); m_addr = a; m_msb = d[7]; m_tog = 0;
    end
    @(negedge clk);
    op_start = 1'b1; op_kind = k; op_addr = a; op_data = d;
    @(negedge clk);
    op_start = 1'b0;
  endtask

  // stand-in timing engine: count cycles, then pulse done
  task automatic run_engine(input int cycles);
    repeat (cycles) @(negedge clk);
    op_done = 1'b1;
    @(negedge clk);
    op_done = 1'b0;
    m_busy = 0;
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset output", rd_data, 8'h00);
    do_read(1, 19'h12345, "R1 first read in read mode");
  endtask

  task automatic t_idle;
    logic [DW-1:0] held;
    do_read(2, 19'h00ABC, "R2 idle oe read");
    do_read(3, 19'h7FFF0, "R2 idle both read");
    held = rd_data;
    rd_addr = 19'h01111;
    repeat (4) @(negedge clk);
    check("R2 hold without read", rd_data, held);
  endtask

  task automatic t_program_low;
    start_op(2'd0, 19'h01234, 8'h35);
    do_read(1, 19'h01234, "R3 program poll msb0 ce");
    do_read(2, 19'h01234, "R7 program toggle oe");
    do_read(1, 19'h01235, "R5 off-target read");
    do_read(3, 19'h01234, "R8 both strobes once");
    do_read(2, 19'h00000, "R8 toggle after both");
    start_op(2'd3, 19'h50000, 8'hFF);
    do_read(1, 19'h01234, "R10 start while busy ignored");
    do_read(1, 19'h50000, "R10 new address not taken");
    run_engine(5);
    do_read(1, 19'h01234, "R9 true data after done");
    do_read(2, 19'h01234, "R9 toggle stopped");
  endtask

  task automatic t_program_high;
    start_op(2'd0, 19'h4A5A5, 8'hA5);
    do_read(2, 19'h4A5A5, "R3 program poll msb1");
    do_read(2, 19'h4A5A5, "R6 low bits zero");
    run_engine(3);
  endtask

  task automatic t_erase;
    start_op(2'd2, 19'h30000, 8'h00);
    do_read(1, 19'h30000, "R4 erase poll zero");
    do_read(1, 19'h3FFFF, "R4 erase toggle");
    do_read(2, 19'h12345, "R5 erase other address");
    run_engine(8);
    do_read(1, 19'h30000, "R9 erase done true data");
  endtask

  task automatic t_toggle_clear;
    start_op(2'd1, 19'h23456, 8'h00);
    do_read(1, 19'h23456, "R7 toggle first");
    run_engine(2);
    start_op(2'd0, 19'h00010, 8'h00);
    do_read(2, 19'h00010, "R7 toggle cleared by start");
    run_engine(2);
  endtask

  initial begin
    t_reset;
    t_idle;
    t_program_low;
    t_program_high;
    t_erase;
    t_toggle_clear;
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule